// File: doc/BRIEF.md
# Rate-Limited Host Notification Pulser

This block tells a host that a peripheral has received data waiting to be read. It drives one active-low notification line. The line idles high (released) and goes low for a short pulse when data is pending. Because the host may be slow to service interrupts, the block caps how often it pulses. After each pulse it waits a fixed recheck interval. During that interval the line stays released whatever the data-available level does.

When the interval expires, the block samples the data-available level again. If data is still pending, it pulses again and starts a new interval. If the buffer has drained, it goes back to idle and waits for the next time data becomes available. A notification the host misses is therefore repeated until the data is taken. No acknowledge path is needed.

The data-available level is brought through a synchronizer before use. The pulse width and the recheck interval are parameters counted in clock cycles. The defaults give about 50 µs and 100 ms at 125 MHz.

Top module: `notify_pacer`

## Requirements
- R1: While reset is held and in the first cycle after it, `notifyN` is 1 (released).
- R2: When `dataPending` rises while the block is idle, `notifyN` goes to 0 exactly SYNC_STAGES+1 rising edges after the first edge that samples the new level. With the default of 2 stages this is 3 edges.
- R3: Every low pulse on `notifyN` lasts exactly PULSE_CYCLES clock cycles. This holds even if `dataPending` falls during the pulse.
- R4: After each pulse, `notifyN` stays 1 for exactly PERIOD_CYCLES cycles before anything else can happen.
- R5: If the synchronized `dataPending` is 1 in the last cycle of that interval, a new pulse starts in the very next cycle. This repeats for as long as data stays pending.
- R6: If the synchronized `dataPending` is 0 in the last cycle of the interval, the block returns to idle and keeps `notifyN` at 1 until `dataPending` rises again.
- R7: If `dataPending` falls and rises again during the interval, no early pulse is produced. The next pulse waits for the interval to end.
- R8: `notifyN` is never 0 for more than PULSE_CYCLES consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataPending | input | 1 | Receive buffer holds unread data (asynchronous level) |
| notifyN | output | 1 | Active-low notification line; 1 = released |

## Verification
The assertions assume that `dataPending` is a level that stays stable for at least one clock around each edge. They also assume it is 0 during reset, so the synchronizer history they look back on is defined. The bench drives `dataPending` only on falling clock edges and holds it low through reset. Its changes are spaced at least a cycle apart, including the short toggles placed inside a recheck interval.

// File: rtl/notify_pacer_pkg.sv
package notify_pacer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PULSE = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;

  typedef struct packed {
    logic clrCnt;   // restart the shared interval counter
    logic lineLow;  // pull the notification line low
  } strobe_t;

endpackage

// File: rtl/notify_pacer_dp.sv
module notify_pacer_dp
  import notify_pacer_pkg::*;
#(
  parameter int PULSE_CYCLES  = 6250,
  parameter int PERIOD_CYCLES = 12500000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    dataPending,
  input  strobe_t strb,
  output logic    pendSync,
  output logic    pulseDone,
  output logic    periodDone,
  output logic    notifyN
);
  localparam int MaxCycles = (PULSE_CYCLES > PERIOD_CYCLES) ? PULSE_CYCLES : PERIOD_CYCLES;
  localparam int CntW      = $clog2(MaxCycles + 1);
  localparam logic [CntW-1:0] PulseLast  = CntW'(PULSE_CYCLES - 1);
  localparam logic [CntW-1:0] PeriodLast = CntW'(PERIOD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CntW-1:0]        tick;

  always_ff @(posedge clk) begin
    if (rst) syncQ[0] <= 1'b0;
    else     syncQ[0] <= dataPending;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) syncQ[s] <= 1'b0;
      else     syncQ[s] <= syncQ[s-1];
    end
  end

  assign pendSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || strb.clrCnt) tick <= '0;
    else                    tick <= tick + 1'b1;
  end

  assign pulseDone  = (tick == PulseLast);
  assign periodDone = (tick == PeriodLast);
  assign notifyN    = ~strb.lineLow;

endmodule

// File: rtl/notify_pacer_ctrl.sv
module notify_pacer_ctrl
  import notify_pacer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pendSync,
  input  logic    pulseDone,
  input  logic    periodDone,
  output strobe_t strb
);
  phase_e phase, phaseNext;

  always_comb begin
    phaseNext   = phase;
    strb.clrCnt = 1'b0;
    strb.lineLow = (phase == PH_PULSE);
    unique case (phase)
      PH_IDLE: begin
        strb.clrCnt = 1'b1;
        if (pendSync) phaseNext = PH_PULSE;
      end
      PH_PULSE: begin
        if (pulseDone) begin
          phaseNext   = PH_HOLD;
          strb.clrCnt = 1'b1;
        end
      end
      PH_HOLD: begin
        if (periodDone) begin
          strb.clrCnt = 1'b1;
          phaseNext   = pendSync ? PH_PULSE : PH_IDLE;
        end
      end
      default: begin
        phaseNext   = PH_IDLE;
        strb.clrCnt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

endmodule

// File: rtl/notify_pacer.sv
module notify_pacer #(
  parameter int PULSE_CYCLES  = 6250,
  parameter int PERIOD_CYCLES = 12500000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dataPending,
  output logic notifyN
);
  notify_pacer_pkg::strobe_t strb;
  logic pendSync, pulseDone, periodDone;

  notify_pacer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .pendSync(pendSync),
    .pulseDone(pulseDone), .periodDone(periodDone), .strb(strb)
  );

  notify_pacer_dp #(
    .PULSE_CYCLES(PULSE_CYCLES), .PERIOD_CYCLES(PERIOD_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst), .dataPending(dataPending), .strb(strb),
    .pendSync(pendSync), .pulseDone(pulseDone), .periodDone(periodDone), .notifyN(notifyN)
  );

endmodule

// File: rtl/notify_pacer_chk.sv
module notify_pacer_chk #(
  parameter int PULSE_CYCLES  = 6250,
  parameter int PERIOD_CYCLES = 12500000,
  parameter int SYNC_STAGES   = 2
) (
  input logic clk,
  input logic rst,
  input logic dataPending,
  input logic notifyN
);
  int unsigned lowRun;
  int unsigned gapRun;
  logic        seenPulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowRun    <= 0;
      gapRun    <= 0;
      seenPulse <= 1'b0;
    end else begin
      lowRun <= notifyN ? 0 : lowRun + 1;
      gapRun <= !notifyN ? 0 : ((gapRun < 32'hFFFF_0000) ? gapRun + 1 : gapRun);
      if (!notifyN) seenPulse <= 1'b1;
    end
  end

  // R1: line released in the cycle following reset
  always @(posedge clk) begin
    if (!rst && $past(rst)) a_r1_released: assert (notifyN);
  end

  // R3: each pulse completes its full width
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(notifyN) |-> lowRun == PULSE_CYCLES);

  // R8: low level never outlasts one pulse
  a_r8_low_bound: assert property (@(posedge clk) disable iff (rst)
    lowRun <= PULSE_CYCLES);

  // R4, R7: pulses are spaced by at least the recheck interval
  a_r4_min_gap: assert property (@(posedge clk) disable iff (rst)
    ($fell(notifyN) && seenPulse) |-> gapRun >= PERIOD_CYCLES);

  // R2, R5: a pulse only starts when the input was high one synchronizer delay earlier
  a_r2_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(notifyN) |-> $past(dataPending, SYNC_STAGES + 1));

endmodule

bind notify_pacer notify_pacer_chk #(
  .PULSE_CYCLES(PULSE_CYCLES), .PERIOD_CYCLES(PERIOD_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .dataPending(dataPending), .notifyN(notifyN)
);

// File: tb/notify_pacer_test.sv
`timescale 1ns/1ps
module notify_pacer_test;
  localparam int PW  = 4;
  localparam int PER = 20;
  localparam int SYN = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dataPending = 1'b0;
  logic notifyN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  notify_pacer #(.PULSE_CYCLES(PW), .PERIOD_CYCLES(PER), .SYNC_STAGES(SYN)) uut (
    .clk(clk), .rst(rst), .dataPending(dataPending), .notifyN(notifyN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 low pulse, 2 waiting interval
  int mPhase = 0;
  int mCount = 0;
  bit mHist[$];

  always @(posedge clk) begin
    bit seen;
    if (rst) begin
      mPhase = 0; mCount = 0;
      mHist.delete();
      for (int i = 0; i < SYN; i++) mHist.push_back(1'b0);
    end else begin
      seen = mHist[SYN-1];
      case (mPhase)
        0: if (seen) begin mPhase = 1; mCount = 0; end
        1: if (mCount == PW - 1) begin mPhase = 2; mCount = 0; end else mCount++;
        default: if (mCount == PER - 1) begin mPhase = seen ? 1 : 0; mCount = 0; end
                 else mCount++;
      endcase
      mHist.push_front(dataPending);
      void'(mHist.pop_back());
    end
  end

  // Compare against the reference on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      case (mPhase)
        0: check(rst ? "R1" : "R6", notifyN, 1);
        1: check("R3", notifyN, 0);
        default: check("R4/R7", notifyN, 1);
      endcase
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic countWhile(input logic lvl, output int n);
    n = 0;
    while (notifyN == lvl && n < 500) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    cycles(3);
    check("R1", notifyN, 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", notifyN, 1);

    // R2: start latency from idle
    dataPending = 1'b1;
    n = 0;
    while (notifyN && n < 50) begin @(negedge clk); n++; end
    check("R2", n, SYN + 1);
    countWhile(1'b0, n);
    check("R3", n, PW);
    countWhile(1'b1, n);
    check("R4", n, PER);
    check("R5", notifyN, 0);

    // R3: drop data mid-pulse, pulse still full width, then idle
    dataPending = 1'b0;
    countWhile(1'b0, n);
    check("R3", n, PW);
    countWhile(1'b1, n);
    check("R6", n, 500);

    // R7: toggle during the interval, no early pulse
    dataPending = 1'b1;
    while (notifyN) @(negedge clk);
    countWhile(1'b0, n);
    check("R3", n, PW);
    cycles(3);
    dataPending = 1'b0;
    cycles(3);
    dataPending = 1'b1;
    countWhile(1'b1, n);
    check("R7", n + 6, PER);

    // R5: repeated pulses while data stays pending
    for (int k = 0; k < 3; k++) begin
      countWhile(1'b0, n);
      check("R8", n, PW);
      countWhile(1'b1, n);
      check("R5", n, PER);
    end
    dataPending = 1'b0;
    cycles(PW + PER + 10);
    check("R6", notifyN, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule